// File: doc/BRIEF.md
# Four-Port GPIO Mode and Interrupt Controller

This block manages four 8-bit general-purpose I/O ports. One 8-bit mode register gives every port a 2-bit code. For each pin, the block combines the port's code, the pin's data latch bit and its interrupt enable bit into three pad controls: drive high, drive low and pull-up enable. The code selects one of three behaviours. A pull-up mode pulls the pin up and can drive it low. An open-drain mode can only drive the pin low. A push-pull mode drives the pin both ways, and in that mode the interrupt enable bits act as per-pin direction bits.

Pin inputs pass through a two-flop synchroniser. An edge of the polarity that the port's code selects sets a sticky per-pin pending bit. The interrupt request is the OR of all pending bits. Software writes and reads all state over a small register bus: the write is taken at the clock edge and the read is combinational.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the data latches read 0xFF, the enable registers read 0x00, no bit is pending, irq_o is 0, and drv_hi_o, drv_lo_o and pull_up_o are all 0.
- R2: A write to address 0x08 loads the mode register: port k takes bits [2k+1:2k]. The register always reads back 0, and reset clears it to 0.
- R3: Address k (0..3) is the data latch of port k and address 4+k is its enable register. Both read back the value last written. Addresses 0x09..0x0B read 0.
- R4: In mode 11 (pull-up), a pin with data 1 has pull_up_o=1 and drv_lo_o=0. A pin with data 0 has pull_up_o=0 and drv_lo_o=1. drv_hi_o is 0 in both cases.
- R5: In modes 00 and 01 (open drain), drv_hi_o and pull_up_o are 0, and drv_lo_o is the inverse of the data bit.
- R6: In mode 10 (push-pull), pull_up_o is 0 and drv_lo_o is the inverse of the data bit. drv_hi_o equals the data bit when the pin's enable bit is 0, and is 0 when the enable bit is 1.
- R7: Mode 00 sets pending on a rising pin edge. Modes 01 and 11 set pending on a falling pin edge. An edge of the other polarity has no effect.
- R8: A port in mode 10 never sets a pending bit.
- R9: A pin whose enable bit is 0 never sets a pending bit.
- R10: Pending bits stay set until cleared. irq_o is the OR of all pending bits. Address 0x0C+k reads the pending bits of port k, and writing a 1 to a bit at that address clears that bit.
- R11: If a clear and a new qualifying edge reach the same pin in the same cycle, the pending bit ends up set.
- R12: A pin change that is first sampled at clock edge A makes the pending bit, and irq_o, visible after edge A+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_i | input | 32 | Pin input levels, port k in bits [8k+7:8k] |
| drv_hi_o | output | 32 | Drive-high enable per pin |
| drv_lo_o | output | 32 | Drive-low enable per pin |
| pull_up_o | output | 32 | Pull-up enable per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is R11, where a software clear and a fresh synchronised edge must land on the same clock edge. Because of the synchroniser delay, the pin has to change two cycles before the clear write. The bench first makes the bit pending, then raises the pin again and issues the clear write exactly two negedges later. It then reads the pending register to confirm the bit survived. A behavioural cycle model covers the rest, including random mode changes made while the pins are moving.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    MODE_OD_RISE = 2'b00,
    MODE_OD_FALL = 2'b01,
    MODE_PUSH    = 2'b10,
    MODE_PULL    = 2'b11
  } port_mode_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NPORT = 4,
  parameter int W     = 8,
  parameter int AW    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [NPORT*W-1:0] pend_i,
  output logic [W-1:0]       rdata_o,
  output logic [NPORT*W-1:0] data_o,
  output logic [NPORT*W-1:0] en_o,
  output logic [2*NPORT-1:0] cfg_o,
  output logic [NPORT*W-1:0] clr_o
);
  localparam int CfgAddr = 2 * NPORT;
  localparam int ClrBase = 3 * NPORT;

  logic [2*NPORT-1:0] cfg_q;
  assign cfg_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_en_i && addr_i == AW'(CfgAddr)) cfg_q <= wdata_i[2*NPORT-1:0];
  end

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic [W-1:0] data_q, en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '1;
        en_q   <= '0;
      end else if (wr_en_i) begin
        if (addr_i == AW'(k))         data_q <= wdata_i;
        if (addr_i == AW'(NPORT + k)) en_q   <= wdata_i;
      end
    end
    assign data_o[k*W +: W] = data_q;
    assign en_o[k*W +: W]   = en_q;
    assign clr_o[k*W +: W]  = (wr_en_i && addr_i == AW'(ClrBase + k)) ? wdata_i : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (addr_i == AW'(k))           rdata_o = data_o[k*W +: W];
      if (addr_i == AW'(NPORT + k))   rdata_o = en_o[k*W +: W];
      if (addr_i == AW'(ClrBase + k)) rdata_o = pend_i[k*W +: W];
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  port_mode_e   mode_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] drv_hi_o,
  output logic [W-1:0] drv_lo_o,
  output logic [W-1:0] pull_up_o
);
  always_comb begin
    drv_lo_o  = ~data_i;
    drv_hi_o  = '0;
    pull_up_o = '0;
    unique case (mode_i)
      MODE_PULL: pull_up_o = data_i;
      MODE_PUSH: drv_hi_o  = data_i & ~en_i;  // enable bits double as direction
      default:   ;
    endcase
  end
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  port_mode_e   mode_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] s1_q, s2_q, prev_q, pend_q, hit;

  always_comb begin
    unique case (mode_i)
      MODE_OD_RISE: hit = s2_q & ~prev_q & en_i;
      MODE_PUSH:    hit = '0;
      default:      hit = ~s2_q & prev_q & en_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      pend_q <= (pend_q & ~clr_i) | hit;  // new edge beats clear
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 8,
  parameter int AW    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [W-1:0]       wdata_i,
  output logic [W-1:0]       rdata_o,
  input  logic [NPORT*W-1:0] pin_i,
  output logic [NPORT*W-1:0] drv_hi_o,
  output logic [NPORT*W-1:0] drv_lo_o,
  output logic [NPORT*W-1:0] pull_up_o,
  output logic               irq_o
);
  localparam int NPIN = NPORT * W;

  logic [NPIN-1:0]    data_w, en_w, clr_w, pend_w;
  logic [2*NPORT-1:0] cfg_q;

  gpio_regs #(.NPORT(NPORT), .W(W), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pend_i (pend_w),
    .rdata_o,
    .data_o (data_w),
    .en_o   (en_w),
    .cfg_o  (cfg_q),
    .clr_o  (clr_w)
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    port_mode_e mode;
    assign mode = port_mode_e'(cfg_q[2*k +: 2]);

    gpio_pad_ctrl #(.W(W)) u_pad (
      .mode_i    (mode),
      .data_i    (data_w[k*W +: W]),
      .en_i      (en_w[k*W +: W]),
      .drv_hi_o  (drv_hi_o[k*W +: W]),
      .drv_lo_o  (drv_lo_o[k*W +: W]),
      .pull_up_o (pull_up_o[k*W +: W])
    );

    gpio_edge_pend #(.W(W)) u_edge (
      .clk_i, .rst_ni,
      .pin_i  (pin_i[k*W +: W]),
      .mode_i (mode),
      .en_i   (en_w[k*W +: W]),
      .clr_i  (clr_w[k*W +: W]),
      .pend_o (pend_w[k*W +: W])
    );
  end

  assign irq_o = |pend_w;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPORT = 4,
  parameter int W     = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2*NPORT-1:0] cfg_q,
  input logic [NPORT*W-1:0] en_w,
  input logic [NPORT*W-1:0] pend_w,
  input logic [NPORT*W-1:0] drv_hi_o,
  input logic [NPORT*W-1:0] drv_lo_o,
  input logic [NPORT*W-1:0] pull_up_o
);
  p_hi_lo_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_hi_o & drv_lo_o) == '0);

  p_pull_no_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & drv_lo_o) == '0);

  p_need_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & ~$past(pend_w) & ~$past(en_w)) == '0);

  for (genvar k = 0; k < NPORT; k++) begin : g_chk
    p_pull_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pull_up_o[k*W +: W]) |-> (cfg_q[2*k +: 2] == 2'b11));

    p_hi_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|drv_hi_o[k*W +: W]) |-> (cfg_q[2*k +: 2] == 2'b10));

    p_no_push_int_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(pend_w[k*W +: W] & ~$past(pend_w[k*W +: W]))) |->
        ($past(cfg_q[2*k +: 2]) != 2'b10));
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPORT(NPORT), .W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_q     (cfg_q),
  .en_w      (en_w),
  .pend_w    (pend_w),
  .drv_hi_o  (drv_hi_o),
  .drv_lo_o  (drv_lo_o),
  .pull_up_o (pull_up_o)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        wr_en_i = 0;
  logic [3:0]  addr_i = 0;
  logic [7:0]  wdata_i = 0;
  logic [31:0] pin_i = 0;
  logic [7:0]  rdata_o;
  logic [31:0] drv_hi_o, drv_lo_o, pull_up_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;

  gpio_port_ctrl u_dut (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i, .drv_hi_o, .drv_lo_o, .pull_up_o, .irq_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model
  bit [7:0]  m_data[4];
  bit [7:0]  m_en[4];
  bit [7:0]  m_cfg;
  bit [31:0] m_pend;
  bit [31:0] hist[$];

  task automatic m_reset();
    for (int k = 0; k < 4; k++) begin m_data[k] = 8'hFF; m_en[k] = 8'h00; end
    m_cfg = 0; m_pend = 0;
    hist = {32'h0, 32'h0, 32'h0};
  endtask

  task automatic m_step();
    bit [31:0] np;
    np = m_pend;
    for (int i = 0; i < 32; i++) begin
      int k = i / 8;
      int b = i % 8;
      int md = (m_cfg >> (2*k)) & 3;
      bit nw = hist[1][i];
      bit od = hist[2][i];
      bit edge_ok = (md == 0) ? (nw && !od) : (!nw && od);
      if (wr_en_i && addr_i == 4'(12 + k) && wdata_i[b]) np[i] = 0;
      if (m_en[k][b] && md != 2 && edge_ok) np[i] = 1;
    end
    if (wr_en_i) begin
      if (addr_i < 4) m_data[addr_i] = wdata_i;
      else if (addr_i < 8) m_en[addr_i-4] = wdata_i;
      else if (addr_i == 8) m_cfg = wdata_i;
    end
    m_pend = np;
    hist.push_front(pin_i);
    void'(hist.pop_back());
  endtask

  task automatic m_compare();
    bit [31:0] ehi, elo, epu;
    bit [7:0]  erd;
    for (int i = 0; i < 32; i++) begin
      int k = i / 8;
      int b = i % 8;
      int md = (m_cfg >> (2*k)) & 3;
      bit d = m_data[k][b];
      elo[i] = !d;
      ehi[i] = (md == 2) && d && !m_en[k][b];
      epu[i] = (md == 3) && d;
    end
    if (addr_i < 4) erd = m_data[addr_i];
    else if (addr_i < 8) erd = m_en[addr_i-4];
    else if (addr_i >= 12) erd = m_pend[8*(addr_i-12) +: 8];
    else erd = 0;
    chk(drv_hi_o == ehi, "R6 drv_hi model", drv_hi_o, ehi);
    chk(drv_lo_o == elo, "R4 R5 R6 drv_lo model", drv_lo_o, elo);
    chk(pull_up_o == epu, "R4 pull_up model", pull_up_o, epu);
    chk(irq_o == (m_pend != 0), "R10 irq model", 32'(irq_o), 32'(m_pend != 0));
    chk(rdata_o == erd, "R3 R10 rdata model", 32'(rdata_o), 32'(erd));
  endtask

  initial m_reset();

  always begin
    @(posedge clk_i);
    if (!rst_ni) m_reset();
    else m_step();
    #(CLK_P/4);
    if (rst_ni) m_compare();
  end

  // stimulus helpers, called and returning at a negedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(rdata_o == exp, tag, 32'(rdata_o), 32'(exp));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_ni = 1;
    wait_n(1);
    // R1 reset state
    chk(drv_hi_o == 0, "R1 drv_hi", drv_hi_o, 0);
    chk(drv_lo_o == 0, "R1 drv_lo", drv_lo_o, 0);
    chk(pull_up_o == 0, "R1 pull_up", pull_up_o, 0);
    chk(irq_o == 0, "R1 irq", 32'(irq_o), 0);
    rd(4'h0, 8'hFF, "R1 data reset");
    rd(4'h4, 8'h00, "R1 enable reset");
    rd(4'hC, 8'h00, "R1 pending reset");

    // R2: port0=00, port1=11, port2=01, port3=10
    wr(4'h8, 8'b10_01_11_00);
    rd(4'h8, 8'h00, "R2 config reads zero");
    chk(pull_up_o == 32'h0000FF00, "R2 port1 field", pull_up_o, 32'h0000FF00);

    // R3
    wr(4'h0, 8'hA5); wr(4'h1, 8'h0F); wr(4'h2, 8'h3C); wr(4'h3, 8'hC3);
    wr(4'h4, 8'h03); wr(4'h5, 8'hFF); wr(4'h6, 8'h00); wr(4'h7, 8'hF0);
    rd(4'h1, 8'h0F, "R3 data1");
    rd(4'h3, 8'hC3, "R3 data3");
    rd(4'h7, 8'hF0, "R3 en3");
    rd(4'h9, 8'h00, "R3 hole");
    chk(pull_up_o == 32'h00000F00, "R4 pull", pull_up_o, 32'h00000F00);
    chk(drv_lo_o[15:8] == 8'hF0, "R4 low drive", 32'(drv_lo_o[15:8]), 32'hF0);
    chk(drv_lo_o[7:0] == 8'h5A, "R5 od low", 32'(drv_lo_o[7:0]), 32'h5A);
    chk(drv_hi_o == 32'h03000000, "R6 push high", drv_hi_o, 32'h03000000);
    chk(drv_lo_o[31:24] == 8'h3C, "R6 push low", 32'(drv_lo_o[31:24]), 32'h3C);

    // R12 latency on pin0 (port0 rising)
    pin_i[0] = 1;
    wait_n(2);
    chk(irq_o == 0, "R12 not before A+2", 32'(irq_o), 0);
    wait_n(1);
    chk(irq_o == 1, "R12 at A+2", 32'(irq_o), 1);
    pin_i[0] = 0;
    wait_n(4);
    rd(4'hC, 8'h01, "R10 sticky");
    wr(4'hC, 8'h01);
    rd(4'hC, 8'h00, "R10 cleared");
    chk(irq_o == 0, "R10 irq low", 32'(irq_o), 0);

    // R11 clear collides with new edge on pin1
    pin_i[1] = 1; wait_n(4); pin_i[1] = 0; wait_n(4);
    rd(4'hC, 8'h02, "R11 setup");
    pin_i[1] = 1;
    wait_n(2);
    wr(4'hC, 8'h02);
    rd(4'hC, 8'h02, "R11 edge wins");
    wr(4'hC, 8'h02);
    rd(4'hC, 8'h00, "R11 later clear");

    // R7 port1 pull-up: falling only
    pin_i[8] = 1; wait_n(4);
    rd(4'hD, 8'h00, "R7 rise ignored");
    pin_i[8] = 0; wait_n(4);
    rd(4'hD, 8'h01, "R7 fall pending");
    wr(4'hD, 8'hFF);
    // R9 port2 enable 0
    pin_i[16] = 1; wait_n(4); pin_i[16] = 0; wait_n(4);
    rd(4'hE, 8'h00, "R9 disabled pin");
    wr(4'h6, 8'hFF);
    pin_i[17] = 1; wait_n(4);
    rd(4'hE, 8'h00, "R7 od-fall rise ignored");
    pin_i[17] = 0; wait_n(4);
    rd(4'hE, 8'h02, "R7 od-fall pending");
    wr(4'hE, 8'hFF);
    // R8 push-pull port
    pin_i[31:24] = 8'hFF; wait_n(4); pin_i[31:24] = 8'h00; wait_n(4);
    rd(4'hF, 8'h00, "R8 push no pending");
    chk(irq_o == 0, "R8 irq", 32'(irq_o), 0);

    // random mix, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      pin_i = $urandom;
      if (($urandom % 3) == 0) wr(4'($urandom % 16), 8'($urandom));
      else begin addr_i = 4'($urandom % 16); wait_n(1); end
    end

    wait_n(2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule